// File: doc/BRIEF.md
# Outbound Window Domain Decoder

This block sorts outbound CPU accesses into isolation domains. It holds a bank of address windows. For each lookup it reports which window claimed the address and which domain number the access belongs to. The address itself goes out unchanged, because the windows do not remap it. Each window covers a naturally aligned power-of-two region of at least 1 MiB. A window works in one of two modes. In single mode, one programmed domain number applies to every address in the window. In segmented mode, the window is split into 256 equal slices, and the slice number itself becomes the domain number, with no lookup table.

Windows may overlap. When they do, the enabled window with the lowest index wins. Software loads each window through a simple write port that carries the enable, base, size exponent, mode and domain fields. Lookups are pipelined with a single register stage, so the result appears one cycle after the request.

Top module: `ob_domain_decoder`

## Requirements
- R1: While reset is active and after it is released, every window is disabled and every output is zero. A lookup made before any configuration write reports no hit.
- R2: The outputs of a lookup appear exactly one clock after `in_valid` is sampled high. `out_valid` is high in that cycle, and `out_addr` equals the request address bit for bit.
- R3: An enabled window whose size exponent is S covers an address when every address bit at position S and above equals the matching base bit. Base bits below position S are ignored. The first byte past the region and the last byte before the base are not covered.
- R4: A segmented window (mode bit 1) reports address bits [S-1:S-8] as the domain number.
- R5: A single-mode window (mode bit 0) reports its programmed 8-bit domain number for every covered address.
- R6: When several enabled windows cover an address, the one with the lowest index is reported, together with its domain number.
- R7: A disabled window never matches. When no enabled window covers a valid request, `out_hit` is low and `out_win` and `out_domain` are zero.
- R8: A written size exponent below 20 behaves as 20, and one above 36 behaves as 36.
- R9: A configuration write takes effect for lookups presented from the next cycle on. A lookup presented in the same cycle as the write still sees the old settings.
- R10: In a cycle after `in_valid` was sampled low, `out_valid`, `out_hit`, `out_win`, `out_domain` and `out_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one window's settings |
| cfg_idx | input | 4 | Window index being written |
| cfg_en | input | 1 | Enable bit for the written window |
| cfg_base | input | 64 | Base address for the written window |
| cfg_size_log2 | input | 6 | Size exponent for the written window (clamped to 20..36) |
| cfg_segmented | input | 1 | Mode: 1 = segmented, 0 = single domain |
| cfg_domain | input | 8 | Domain number used in single mode |
| in_valid | input | 1 | Lookup request strobe |
| in_addr | input | 64 | Address to decode |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_hit | output | 1 | Some enabled window covered the address |
| out_win | output | 4 | Index of the winning window |
| out_domain | output | 8 | Domain number of the access |
| out_addr | output | 64 | The request address, untranslated |

## Verification
The checker assumes that configuration writes never touch a window in a way that must be visible to a lookup in the same cycle. It also treats `in_valid` and `in_addr` as sampled only at clock edges. The bench drives every input on the falling edge, so both hold. The priority property compares the result against the per-window match vector captured one cycle earlier. It therefore relies on the window settings not changing between that capture and the output register. The bench makes a same-cycle write only in the one directed case for R9, which is built around exactly that timing. Random stimulus places most addresses inside randomly configured windows that are packed into a narrow high region so that they overlap often. The rest of the addresses are fully random and exercise the no-hit path.

// File: rtl/obwin_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the outbound window decoder.
// Assumes nothing beyond a 2-state view of the mode bit.
package obwin_pkg;

    // Window operating mode
    typedef enum logic {
        MODE_SINGLE    = 1'b0,
        MODE_SEGMENTED = 1'b1
    } win_mode_e;

    // Saturate a requested size exponent into the legal range
    function automatic logic [5:0] clamp_size(input logic [5:0] req,
                                              input logic [5:0] lo,
                                              input logic [5:0] hi);
        logic [5:0] res;
        if (req < lo)
            res = lo;
        else if (req > hi)
            res = hi;
        else
            res = req;
        return res;
    endfunction

endpackage

// File: rtl/obwin_cfg_bank.sv
`timescale 1ns/1ps
// Register bank holding the settings of every window.
// One window is written per cycle through the cfg_* port. The size exponent
// is saturated into [MIN_LOG2, MAX_LOG2] on the way in.
// Assumes cfg_idx < NUM_WIN; other indices write nothing.
module obwin_cfg_bank #(
    parameter int NUM_WIN  = 16,
    parameter int ADDR_W   = 64,
    parameter int DOM_W    = 8,
    parameter int SZ_W     = 6,
    parameter int MIN_LOG2 = 20,
    parameter int MAX_LOG2 = 36,
    localparam int WIN_W   = $clog2(NUM_WIN)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [WIN_W-1:0]              cfg_idx,
    input  logic                          cfg_en,
    input  logic [ADDR_W-1:0]             cfg_base,
    input  logic [SZ_W-1:0]               cfg_size_log2,
    input  logic                          cfg_segmented,
    input  logic [DOM_W-1:0]              cfg_domain,
    output logic [NUM_WIN-1:0]            win_en,
    output logic [NUM_WIN-1:0][ADDR_W-1:0] win_base,
    output logic [NUM_WIN-1:0][SZ_W-1:0]  win_size,
    output obwin_pkg::win_mode_e [NUM_WIN-1:0] win_mode,
    output logic [NUM_WIN-1:0][DOM_W-1:0] win_dom
);
    import obwin_pkg::*;

    localparam logic [SZ_W-1:0] SZ_LO = SZ_W'(MIN_LOG2);
    localparam logic [SZ_W-1:0] SZ_HI = SZ_W'(MAX_LOG2);

    logic [SZ_W-1:0] size_sat;

    // Saturate the incoming size exponent once, shared by all windows
    always_comb begin
        size_sat = SZ_W'(clamp_size(6'(cfg_size_log2), 6'(SZ_LO), 6'(SZ_HI)));
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        // Hold one window's settings; update when it is addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_en[w]   <= 1'b0;
                win_base[w] <= '0;
                win_size[w] <= SZ_LO;
                win_mode[w] <= MODE_SINGLE;
                win_dom[w]  <= '0;
            end else if (cfg_we && (cfg_idx == WIN_W'(w))) begin
                win_en[w]   <= cfg_en;
                win_base[w] <= cfg_base;
                win_size[w] <= size_sat;
                win_mode[w] <= cfg_segmented ? MODE_SEGMENTED : MODE_SINGLE;
                win_dom[w]  <= cfg_domain;
            end
        end
    end

endmodule

// File: rtl/obwin_match.sv
`timescale 1ns/1ps
// Address compare for one window.
// Reports a hit when the address lies inside the aligned region and derives
// the domain number from the mode. Base bits below the size are ignored.
// Assumes size >= DOM_W so the segment field sits inside the address.
module obwin_match #(
    parameter int ADDR_W = 64,
    parameter int DOM_W  = 8,
    parameter int SZ_W   = 6
) (
    input  logic                 en,
    input  logic [ADDR_W-1:0]    base,
    input  logic [SZ_W-1:0]      size,
    input  obwin_pkg::win_mode_e mode,
    input  logic [DOM_W-1:0]     dom,
    input  logic [ADDR_W-1:0]    addr,
    output logic                 hit,
    output logic [DOM_W-1:0]     domain
);
    import obwin_pkg::*;

    localparam logic [SZ_W-1:0] SEG_FIELD = SZ_W'(DOM_W);

    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] seg_shifted;
    logic [SZ_W-1:0]   seg_lsb;

    // Build the mask of address bits that must equal the base
    always_comb begin
        keep_mask = {ADDR_W{1'b1}} << size;
        hit       = en && (((addr ^ base) & keep_mask) == '0);
    end

    // Pick the domain: segment field in segmented mode, programmed value otherwise
    always_comb begin
        seg_lsb     = size - SEG_FIELD;
        seg_shifted = addr >> seg_lsb;
        if (mode == MODE_SEGMENTED)
            domain = seg_shifted[DOM_W-1:0];
        else
            domain = dom;
    end

endmodule

// File: rtl/obwin_prio_sel.sv
`timescale 1ns/1ps
// Fixed-priority selector: the lowest-index asserted hit wins.
// Outputs are zero when no hit is asserted.
module obwin_prio_sel #(
    parameter int NUM_WIN = 16,
    parameter int DOM_W   = 8,
    localparam int WIN_W  = $clog2(NUM_WIN)
) (
    input  logic [NUM_WIN-1:0]            hits,
    input  logic [NUM_WIN-1:0][DOM_W-1:0] doms,
    output logic                          any_hit,
    output logic [WIN_W-1:0]              sel_idx,
    output logic [DOM_W-1:0]              sel_dom
);

    // Scan from the top down so the lowest index is written last
    always_comb begin
        any_hit = 1'b0;
        sel_idx = '0;
        sel_dom = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any_hit = 1'b1;
                sel_idx = WIN_W'(i);
                sel_dom = doms[i];
            end
        end
    end

endmodule

// File: rtl/ob_domain_decoder.sv
`timescale 1ns/1ps
// Outbound window domain decoder (top).
// Matches a request address against NUM_WIN windows, picks the lowest-index
// hit, and registers hit, window, domain and the untranslated address.
// Latency is one cycle. Outputs are zero in cycles without a request.
// Assumes configuration and lookups share one clock.
module ob_domain_decoder #(
    parameter int NUM_WIN  = 16,
    parameter int ADDR_W   = 64,
    parameter int DOM_W    = 8,
    parameter int MIN_LOG2 = 20,
    parameter int MAX_LOG2 = 36,
    localparam int WIN_W   = $clog2(NUM_WIN),
    localparam int SZ_W    = $clog2(MAX_LOG2 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WIN_W-1:0]  cfg_idx,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [SZ_W-1:0]   cfg_size_log2,
    input  logic              cfg_segmented,
    input  logic [DOM_W-1:0]  cfg_domain,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic              out_hit,
    output logic [WIN_W-1:0]  out_win,
    output logic [DOM_W-1:0]  out_domain,
    output logic [ADDR_W-1:0] out_addr
);
    import obwin_pkg::*;

    logic [NUM_WIN-1:0]             win_en;
    logic [NUM_WIN-1:0][ADDR_W-1:0] win_base;
    logic [NUM_WIN-1:0][SZ_W-1:0]   win_size;
    win_mode_e [NUM_WIN-1:0]        win_mode;
    logic [NUM_WIN-1:0][DOM_W-1:0]  win_dom;

    logic [NUM_WIN-1:0]             win_hit;
    logic [NUM_WIN-1:0][DOM_W-1:0]  win_domain;

    logic              any_hit;
    logic [WIN_W-1:0]  sel_idx;
    logic [DOM_W-1:0]  sel_dom;

    obwin_cfg_bank #(
        .NUM_WIN  (NUM_WIN),
        .ADDR_W   (ADDR_W),
        .DOM_W    (DOM_W),
        .SZ_W     (SZ_W),
        .MIN_LOG2 (MIN_LOG2),
        .MAX_LOG2 (MAX_LOG2)
    ) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_idx       (cfg_idx),
        .cfg_en        (cfg_en),
        .cfg_base      (cfg_base),
        .cfg_size_log2 (cfg_size_log2),
        .cfg_segmented (cfg_segmented),
        .cfg_domain    (cfg_domain),
        .win_en        (win_en),
        .win_base      (win_base),
        .win_size      (win_size),
        .win_mode      (win_mode),
        .win_dom       (win_dom)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        obwin_match #(
            .ADDR_W (ADDR_W),
            .DOM_W  (DOM_W),
            .SZ_W   (SZ_W)
        ) u_match (
            .en     (win_en[w]),
            .base   (win_base[w]),
            .size   (win_size[w]),
            .mode   (win_mode[w]),
            .dom    (win_dom[w]),
            .addr   (in_addr),
            .hit    (win_hit[w]),
            .domain (win_domain[w])
        );
    end

    obwin_prio_sel #(
        .NUM_WIN (NUM_WIN),
        .DOM_W   (DOM_W)
    ) u_prio (
        .hits    (win_hit),
        .doms    (win_domain),
        .any_hit (any_hit),
        .sel_idx (sel_idx),
        .sel_dom (sel_dom)
    );

    // Result register: capture a lookup, clear everything when idle
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid  <= 1'b0;
            out_hit    <= 1'b0;
            out_win    <= '0;
            out_domain <= '0;
            out_addr   <= '0;
        end else begin
            out_valid  <= 1'b1;
            out_hit    <= any_hit;
            out_win    <= sel_idx;
            out_domain <= sel_dom;
            out_addr   <= in_addr;
        end
    end

endmodule

// File: rtl/obwin_decoder_chk.sv
`timescale 1ns/1ps
// Property checker for ob_domain_decoder, attached by bind.
// Observes ports plus the per-window match vector driven by the compare units.
module obwin_decoder_chk #(
    parameter int NUM_WIN = 16,
    parameter int ADDR_W  = 64,
    parameter int DOM_W   = 8,
    localparam int WIN_W  = $clog2(NUM_WIN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out_valid,
    input logic              out_hit,
    input logic [WIN_W-1:0]  out_win,
    input logic [DOM_W-1:0]  out_domain,
    input logic [ADDR_W-1:0] out_addr,
    input logic [NUM_WIN-1:0] hit_vec
);

    logic [NUM_WIN-1:0] hits_q;

    // Keep last cycle's match vector for the priority check
    always_ff @(posedge clk) begin
        if (!rst_n)
            hits_q <= '0;
        else
            hits_q <= hit_vec;
    end

    // R2: a request yields a result one cycle later with its address intact
    a_r2_latency_addr: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && out_addr == $past(in_addr)));

    // R10: no request means a quiet output next cycle
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_hit && out_win == '0
                       && out_domain == '0 && out_addr == '0));

    // R7: a miss reports zero window and domain
    a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> (out_win == '0 && out_domain == '0));

    // R6: the reported window matched and no lower window did
    a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> (hits_q[out_win]
                     && ((hits_q & ((NUM_WIN'(1) << out_win) - NUM_WIN'(1))) == '0)));

    // R7: any matching window on a request produces a hit
    a_r7_hit_when_match: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hit_vec != '0) |=> out_hit);

endmodule

bind ob_domain_decoder obwin_decoder_chk #(
    .NUM_WIN (NUM_WIN),
    .ADDR_W  (ADDR_W),
    .DOM_W   (DOM_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_addr    (in_addr),
    .out_valid  (out_valid),
    .out_hit    (out_hit),
    .out_win    (out_win),
    .out_domain (out_domain),
    .out_addr   (out_addr),
    .hit_vec    (win_hit)
);

// File: tb/ob_domain_decoder_test.sv
`timescale 1ns/1ps
module ob_domain_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic        cfg_en = 1'b0;
    logic [63:0] cfg_base = '0;
    logic [5:0]  cfg_size_log2 = '0;
    logic        cfg_segmented = 1'b0;
    logic [7:0]  cfg_domain = '0;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic        out_valid;
    logic        out_hit;
    logic [3:0]  out_win;
    logic [7:0]  out_domain;
    logic [63:0] out_addr;

    int checks = 0;
    int failures = 0;

    // bench-side copy of the programmed settings
    logic        m_en  [16];
    logic [63:0] m_base[16];
    int          m_sz  [16];
    logic        m_seg [16];
    logic [7:0]  m_dom [16];

    always #4 clk = ~clk;

    ob_domain_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_size_log2(cfg_size_log2),
        .cfg_segmented(cfg_segmented), .cfg_domain(cfg_domain),
        .in_valid(in_valid), .in_addr(in_addr), .out_valid(out_valid),
        .out_hit(out_hit), .out_win(out_win), .out_domain(out_domain),
        .out_addr(out_addr)
    );

    function automatic int clamp_sz(input int s);
        if (s < 20) return 20;
        if (s > 36) return 36;
        return s;
    endfunction

    function automatic void model(input logic [63:0] a, output logic hit,
                                  output logic [3:0] win, output logic [7:0] dom);
        hit = 1'b0; win = '0; dom = '0;
        for (int i = 15; i >= 0; i--) begin
            logic [63:0] mask;
            mask = {64{1'b1}} << m_sz[i];
            if (m_en[i] && (((a ^ m_base[i]) & mask) == 64'd0)) begin
                hit = 1'b1;
                win = 4'(i);
                dom = m_seg[i] ? 8'((a >> (m_sz[i] - 8)) & 64'hFF) : m_dom[i];
            end
        end
    endfunction

    task automatic put_cfg(input int idx, input logic en, input logic [63:0] base,
                           input int sz, input logic seg, input logic [7:0] dom);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_en = en; cfg_base = base;
        cfg_size_log2 = 6'(sz); cfg_segmented = seg; cfg_domain = dom;
        m_en[idx] = en; m_base[idx] = base; m_sz[idx] = clamp_sz(sz);
        m_seg[idx] = seg; m_dom[idx] = dom;
    endtask

    task automatic write_cfg(input int idx, input logic en, input logic [63:0] base,
                             input int sz, input logic seg, input logic [7:0] dom);
        @(negedge clk);
        put_cfg(idx, en, base, sz, seg, dom);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic check_out(input string tag, input logic e_hit,
                             input logic [3:0] e_win, input logic [7:0] e_dom,
                             input logic [63:0] e_addr);
        checks++;
        if (!(out_valid === 1'b1 && out_hit === e_hit && out_win === e_win
              && out_domain === e_dom && out_addr === e_addr)) begin
            failures++;
            $display("FAIL %s: got v=%0b hit=%0b win=%0d dom=%02h addr=%016h exp v=1 hit=%0b win=%0d dom=%02h addr=%016h",
                     tag, out_valid, out_hit, out_win, out_domain, out_addr,
                     e_hit, e_win, e_dom, e_addr);
        end
    endtask

    task automatic lookup(input logic [63:0] a, input string tag,
                          input logic e_hit, input logic [3:0] e_win,
                          input logic [7:0] e_dom);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        check_out(tag, e_hit, e_win, e_dom, a);
        in_valid = 1'b0; in_addr = '0;
    endtask

    task automatic check_idle(input string tag);
        @(negedge clk);
        checks++;
        if (!(out_valid === 1'b0 && out_hit === 1'b0 && out_win === 4'd0
              && out_domain === 8'd0 && out_addr === 64'd0)) begin
            failures++;
            $display("FAIL %s: got v=%0b hit=%0b win=%0d dom=%02h addr=%016h exp all zero",
                     tag, out_valid, out_hit, out_win, out_domain, out_addr);
        end
    endtask

    // watchdog
    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic        e_hit;
        logic [3:0]  e_win;
        logic [7:0]  e_dom;
        void'($urandom(32'd20250611));
        for (int i = 0; i < 16; i++) begin
            m_en[i] = 1'b0; m_base[i] = '0; m_sz[i] = 20; m_seg[i] = 1'b0; m_dom[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs zero during reset
        check_idle("R1 in reset");
        rst_n = 1'b1;
        check_idle("R1 after reset");
        lookup(64'h0000_0001_2345_6789, "R1 no window after reset", 1'b0, 4'd0, 8'd0);
        // R10: quiet cycle after a request
        check_idle("R10 idle after lookup");

        // R3: 1 MiB single window with junk low base bits
        write_cfg(3, 1'b1, 64'h0000_0001_1000_1234, 20, 1'b0, 8'h3C);
        lookup(64'h0000_0001_0FFF_FFFF, "R3 below base", 1'b0, 4'd0, 8'd0);
        lookup(64'h0000_0001_1000_0000, "R3 first byte", 1'b1, 4'd3, 8'h3C);
        lookup(64'h0000_0001_100F_FFFF, "R3 last byte", 1'b1, 4'd3, 8'h3C);
        lookup(64'h0000_0001_1010_0000, "R3 past end", 1'b0, 4'd0, 8'd0);

        // R4: segmented 16 MiB window, domain = bits 23:16
        write_cfg(5, 1'b1, 64'h0000_0002_0000_0000, 24, 1'b1, 8'hEE);
        lookup(64'h0000_0002_00AB_CDEF, "R4 segment AB", 1'b1, 4'd5, 8'hAB);
        lookup(64'h0000_0002_00FF_FFFF, "R4 top segment", 1'b1, 4'd5, 8'hFF);
        lookup(64'h0000_0002_0000_0010, "R4 segment 0", 1'b1, 4'd5, 8'h00);

        // R5: single-mode window gives programmed domain everywhere
        write_cfg(8, 1'b1, 64'h0000_0003_0000_0000, 28, 1'b0, 8'h5A);
        lookup(64'h0000_0003_0ABC_0000, "R5 single domain", 1'b1, 4'd8, 8'h5A);
        lookup(64'h0000_0003_0FFF_FFFF, "R5 single domain top", 1'b1, 4'd8, 8'h5A);

        // R6: window 2 overlaps window 8, lower index wins
        write_cfg(2, 1'b1, 64'h0000_0003_0A00_0000, 24, 1'b0, 8'h22);
        lookup(64'h0000_0003_0A12_3456, "R6 lower index wins", 1'b1, 4'd2, 8'h22);
        lookup(64'h0000_0003_0B12_3456, "R6 outside lower window", 1'b1, 4'd8, 8'h5A);
        // R7: disabling window 2 hands the region back to window 8
        write_cfg(2, 1'b0, 64'h0000_0003_0A00_0000, 24, 1'b0, 8'h22);
        lookup(64'h0000_0003_0A12_3456, "R7 disabled window skipped", 1'b1, 4'd8, 8'h5A);
        write_cfg(8, 1'b0, 64'h0000_0003_0000_0000, 28, 1'b0, 8'h5A);
        lookup(64'h0000_0003_0ABC_0000, "R7 all disabled miss", 1'b0, 4'd0, 8'd0);

        // R8: size 5 behaves as 20
        write_cfg(4, 1'b1, 64'h0000_0004_0000_0000, 5, 1'b0, 8'h11);
        lookup(64'h0000_0004_000F_FFFF, "R8 low clamp inside", 1'b1, 4'd4, 8'h11);
        lookup(64'h0000_0004_0010_0000, "R8 low clamp outside", 1'b0, 4'd0, 8'd0);
        // R8: size 50 behaves as 36 (covers 0 .. 0xF_FFFF_FFFF)
        write_cfg(4, 1'b1, 64'h0000_0004_0000_0000, 50, 1'b1, 8'h11);
        lookup(64'h0000_000F_F300_0000, "R8 high clamp segment", 1'b1, 4'd4, 8'hFF);
        lookup(64'h0000_0010_0000_0000, "R8 high clamp outside", 1'b0, 4'd0, 8'd0);
        write_cfg(4, 1'b0, 64'h0, 20, 1'b0, 8'h00);

        // R9: write and lookup in the same cycle
        write_cfg(9, 1'b1, 64'h0000_0006_0000_0000, 20, 1'b0, 8'h33);
        @(negedge clk);
        put_cfg(9, 1'b1, 64'h0000_0006_0000_0000, 20, 1'b0, 8'h44);
        in_valid = 1'b1; in_addr = 64'h0000_0006_0000_0100;
        @(negedge clk);
        cfg_we = 1'b0;
        check_out("R9 same-cycle sees old", 1'b1, 4'd9, 8'h33, 64'h0000_0006_0000_0100);
        in_valid = 1'b0; in_addr = '0;
        lookup(64'h0000_0006_0000_0100, "R9 next cycle sees new", 1'b1, 4'd9, 8'h44);
        check_idle("R10 idle after R9");

        // Random phase: windows packed into one 64 GiB region to overlap
        for (int round = 0; round < 8; round++) begin
            for (int w = 0; w < 16; w++) begin
                logic [63:0] b;
                int sz;
                b = {$urandom(), $urandom()} & 64'h0000_000F_FFFF_FFFF;
                b = b | 64'h0000_0700_0000_0000;
                sz = (($urandom() % 8) == 0) ? int'($urandom() % 64) : 20 + int'($urandom() % 17);
                write_cfg(w, ($urandom() % 5) != 0, b, sz, $urandom() % 2 == 1, 8'($urandom()));
            end
            for (int n = 0; n < 250; n++) begin
                logic [63:0] a;
                int pick;
                pick = int'($urandom() % 16);
                if (($urandom() % 6) == 0)
                    a = {$urandom(), $urandom()};
                else
                    a = (m_base[pick] & ({64{1'b1}} << m_sz[pick]))
                        | ({$urandom(), $urandom()} & ~({64{1'b1}} << m_sz[pick]));
                model(a, e_hit, e_win, e_dom);
                if (!e_hit)
                    lookup(a, "R7 random miss", e_hit, e_win, e_dom);
                else if (m_seg[e_win])
                    lookup(a, "R4 R6 random segmented", e_hit, e_win, e_dom);
                else
                    lookup(a, "R5 R6 random single", e_hit, e_win, e_dom);
            end
        end
        check_idle("R10 final idle");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule